// File: doc/BRIEF.md
# SDRAM Command and Refresh Controller

This block sits between a simple host port and one external SDRAM device with four banks, a 16-bit data bus and row and column addresses that share one set of address pins. The host gives a flat word address, a write flag, write data and a byte-enable pair. When the controller shows ready, it accepts the request. It opens the addressed row, issues a single column access with auto-precharge, and leaves every bank closed again. Read data goes back to the host with a one-cycle valid strobe.

After reset the controller holds the clock enable low for one cycle. It then drives NOPs for a programmable power-up time and runs the start-up sequence: a precharge of all banks, two auto refreshes, and a mode load that selects a burst of one, sequential order and the configured CAS latency. After that it serves host requests. A free-running interval counter raises a refresh request. That request is served as soon as the current access has finished, and it wins over any waiting host request. The activate-to-column, precharge and refresh recovery times are parameters in clock cycles. The controller fills the gaps with NOPs.

Top module: `sdram_ctrl`

## Requirements
- R1: While reset is held, clock enable is low, the command is NOP ({cs_n,ras_n,cas_n,we_n} = 0111), req_ready is low and rd_valid is low.
- R2: No command other than NOP is issued before T_INIT clocks have passed since reset release, and only while clock enable is high and was high in the previous cycle. The first command is a precharge of all banks (0010 with address bit 10 high).
- R3: After the first precharge come exactly two auto refreshes (0001), then a mode load (0000) with bank 0 and an address word whose bits 6:4 hold CAS_LAT and whose other bits are zero. req_ready stays low until that mode load has been issued.
- R4: req_addr[22:21] is the bank, req_addr[20:9] the row and req_addr[8:0] the column. The activate command (0011) carries the bank and row. The following read (0101) or write (0100) carries the same bank and the column on address bits 8:0.
- R5: Every read and write command has address bit 10 high, so that it precharges automatically.
- R6: A column command comes at least T_RCD cycles after its activate. Any command comes at least T_RFC cycles after an auto refresh.
- R7: In the write command cycle the output enable is high, the data pins carry the write data, and sd_dqm is the inverse of the byte enables (bit 0 covers the low byte). A byte whose enable is low keeps its old contents in memory.
- R8: rd_valid is high for one cycle, CAS_LAT+1 cycles after the read command first appears on the pins. rd_data carries the word at the requested address. Results come back in request order.
- R9: On a read, sd_dqm is the inverse of the byte enables. A byte lane whose enable is low is returned as 0x00 whatever the data pins show.
- R10: Once initialisation is over, consecutive auto refreshes are at most REFI plus one access plus one refresh time apart under any traffic. An idle controller still refreshes about every REFI cycles. A due refresh is issued before any new host request.
- R11: Read capture works for CAS_LAT = 2 and CAS_LAT = 3.
- R12: The data output enable is high only in a write command cycle, and it is low during read commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Flat word address {bank, row, column} |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| req_ready | output | 1 | Request accepted on a rising edge when valid and ready |
| rd_data | output | 16 | Read data, disabled bytes zeroed |
| rd_valid | output | 1 | One-cycle strobe marking rd_data |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Memory chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Shared row / column address, bit 10 = auto-precharge |
| sd_dqm | output | 2 | Byte data masks, high = masked |
| sd_dq_out | output | 16 | Data toward memory |
| sd_dq_oe | output | 1 | Output enable for the data pads |
| sd_dq_in | input | 16 | Data from memory |

## Verification
The bench goes after the read-capture point at both CAS latencies. A pipeline that is one stage short or long would return the idle bus value or the wrong word, and the latency count would no longer be four or three cycles. It writes with only one byte enabled and then reads back with each byte disabled in turn. A controller that drops the mask corrupts the neighbouring byte, and one that forgets the read-side zeroing returns the model's 0xFF filler. It also places the highest address and addresses spread over all banks on the pins and compares each field. A swapped bank or row slice shows up there, even though such a controller would still read back its own writes consistently. Refresh gaps are measured under a continuous request stream and while idle. A controller that let host requests starve a due refresh would exceed the gap bound.

// File: rtl/sdram_ctrl.sv
module sdram_ctrl #(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 9,
  parameter int DQ_W    = 16,
  parameter int CAS_LAT = 2,
  parameter int T_INIT  = 20000,
  parameter int T_RP    = 2,
  parameter int T_RCD   = 2,
  parameter int T_RFC   = 7,
  parameter int T_MRD   = 2,
  parameter int REFI    = 1560
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic                            req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
  input  logic [DQ_W-1:0]                 req_wdata,
  input  logic [DQ_W/8-1:0]               req_be,
  output logic                            req_ready,
  output logic [DQ_W-1:0]                 rd_data,
  output logic                            rd_valid,
  output logic                            sd_cke,
  output logic                            sd_cs_n,
  output logic                            sd_ras_n,
  output logic                            sd_cas_n,
  output logic                            sd_we_n,
  output logic [BANK_W-1:0]               sd_ba,
  output logic [ROW_W-1:0]                sd_addr,
  output logic [DQ_W/8-1:0]               sd_dqm,
  output logic [DQ_W-1:0]                 sd_dq_out,
  output logic                            sd_dq_oe,
  input  logic [DQ_W-1:0]                 sd_dq_in
);
  localparam int AW = BANK_W + ROW_W + COL_W;
  localparam int NB = DQ_W / 8;
  localparam int TW = $clog2(T_INIT + CAS_LAT + T_RP + T_RFC + T_RCD + T_MRD + 2);
  localparam int RW = $clog2(REFI + 1);
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD  = 4'b0101,
                         C_WR  = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_MRS = 4'b0000;
  localparam logic [ROW_W-1:0] AP_BIT    = ROW_W'(1 << 10);
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

  typedef enum logic [2:0] {ST_PWR, ST_REF1, ST_REF2, ST_MODE, ST_IDLE, ST_COL} st_t;

  st_t              st;
  logic [TW-1:0]    tmr;
  logic [RW-1:0]    ref_cnt;
  logic             ref_pend, live;
  logic [3:0]       cmd;
  logic             op_wr;
  logic [COL_W-1:0] op_col;
  logic [DQ_W-1:0]  op_data;
  logic [NB-1:0]    op_be;
  logic [CAS_LAT:0] rd_pipe;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign req_ready = (st == ST_IDLE) && (tmr == '0) && !ref_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_PWR;     tmr <= TW'(T_INIT); cmd <= C_NOP;  sd_cke <= 1'b0;
      sd_ba <= '0;      sd_addr <= '0;      sd_dqm <= '0;  sd_dq_out <= '0;
      sd_dq_oe <= 1'b0; ref_cnt <= '0;      ref_pend <= 1'b0; live <= 1'b0;
      op_wr <= 1'b0;    op_col <= '0;       op_data <= '0; op_be <= '0;
      rd_pipe <= '0;    rd_valid <= 1'b0;   rd_data <= '0;
    end else begin
      sd_cke   <= 1'b1;
      cmd      <= C_NOP;
      sd_dq_oe <= 1'b0;
      sd_dqm   <= '0;
      rd_pipe  <= {rd_pipe[CAS_LAT-1:0], 1'b0};
      rd_valid <= rd_pipe[CAS_LAT];
      if (rd_pipe[CAS_LAT])
        for (int i = 0; i < NB; i++)
          rd_data[8*i +: 8] <= op_be[i] ? sd_dq_in[8*i +: 8] : 8'h00;

      if (tmr != '0) tmr <= tmr - 1'b1;
      else begin
        case (st)
          ST_PWR: begin
            cmd <= C_PRE; sd_addr <= AP_BIT; tmr <= TW'(T_RP - 1); st <= ST_REF1;
          end
          ST_REF1: begin cmd <= C_REF; tmr <= TW'(T_RFC - 1); st <= ST_REF2; end
          ST_REF2: begin cmd <= C_REF; tmr <= TW'(T_RFC - 1); st <= ST_MODE; end
          ST_MODE: begin
            cmd <= C_MRS; sd_ba <= '0; sd_addr <= MODE_WORD;
            tmr <= TW'(T_MRD - 1); st <= ST_IDLE; live <= 1'b1;
          end
          ST_IDLE: begin
            if (ref_pend) begin
              cmd <= C_REF; ref_pend <= 1'b0; tmr <= TW'(T_RFC - 1);
            end else if (req_valid) begin
              cmd     <= C_ACT;
              sd_ba   <= req_addr[AW-1 -: BANK_W];
              sd_addr <= req_addr[COL_W +: ROW_W];
              op_wr   <= req_write;
              op_col  <= req_addr[COL_W-1:0];
              op_data <= req_wdata;
              op_be   <= req_be;
              tmr     <= TW'(T_RCD - 1);
              st      <= ST_COL;
            end
          end
          ST_COL: begin
            cmd        <= op_wr ? C_WR : C_RD;
            sd_addr    <= ROW_W'(op_col) | AP_BIT;
            sd_dqm     <= ~op_be;
            sd_dq_oe   <= op_wr;
            sd_dq_out  <= op_data;
            rd_pipe[0] <= !op_wr;
            tmr        <= op_wr ? TW'(T_RP) : TW'(CAS_LAT + T_RP);
            st         <= ST_IDLE;
          end
          default: st <= ST_PWR;
        endcase
      end

      if (live) begin
        if (ref_cnt == RW'(REFI - 1)) begin
          ref_cnt  <= '0;
          ref_pend <= 1'b1;
        end else ref_cnt <= ref_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdram_ctrl_chk.sv
module sdram_ctrl_chk #(
  parameter int CAS_LAT = 2,
  parameter int T_RP    = 2,
  parameter int T_RCD   = 2,
  parameter int T_RFC   = 7,
  parameter int T_MRD   = 2,
  parameter int REFI    = 1560
) (
  input logic clk,
  input logic rst_n,
  input logic sd_cke,
  input logic sd_cs_n,
  input logic sd_ras_n,
  input logic sd_cas_n,
  input logic sd_we_n,
  input logic sd_ap,
  input logic sd_dq_oe,
  input logic rd_valid,
  input logic req_ready
);
  localparam int LIM = REFI + T_RCD + CAS_LAT + T_RP + T_RFC + T_MRD + 4;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR  = 4'b0100, C_REF = 4'b0001, C_MRS = 4'b0000;

  logic [3:0] c;
  int         act_age, ref_age;
  logic       seen_mode;
  assign c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_age <= 0; ref_age <= 0; seen_mode <= 1'b0;
    end else begin
      act_age <= (c == C_ACT) ? 1 : ((act_age < LIM) ? act_age + 1 : act_age);
      ref_age <= (c == C_REF) ? 1 : ((ref_age < LIM + 1) ? ref_age + 1 : ref_age);
      if (c == C_MRS) seen_mode <= 1'b1;
    end
  end

  assert_cke_before_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (c != C_NOP) |-> (sd_cke && $past(sd_cke))) else $error("command without clock enable");
  assert_ready_after_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_mode |-> !req_ready) else $error("ready before mode load");
  assert_col_autopre_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (c == C_RD || c == C_WR) |-> sd_ap) else $error("column command without auto-precharge");
  assert_act_to_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (c == C_RD || c == C_WR) |-> (act_age >= T_RCD)) else $error("activate-to-column too short");
  assert_ref_recovery_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (c != C_NOP) |-> (ref_age >= T_RFC)) else $error("command inside refresh recovery");
  assert_rd_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(c == C_RD, CAS_LAT + 1)) else $error("read strobe misaligned");
  assert_refresh_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seen_mode |-> (ref_age <= LIM)) else $error("refresh overdue");
  assert_oe_write_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (c == C_WR)) else $error("output enable outside write");
endmodule

bind sdram_ctrl sdram_ctrl_chk #(
  .CAS_LAT(CAS_LAT), .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC), .T_MRD(T_MRD), .REFI(REFI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ap(sd_addr[10]), .sd_dq_oe(sd_dq_oe),
  .rd_valid(rd_valid), .req_ready(req_ready)
);

// File: tb/sdram_model.sv
module sdram_model #(
  parameter int CL = 2
) (
  input  logic        clk,
  input  logic        cs_n,
  input  logic        ras_n,
  input  logic        cas_n,
  input  logic        we_n,
  input  logic [1:0]  ba,
  input  logic [11:0] addr,
  input  logic [1:0]  dqm,
  input  logic [15:0] dq_out,
  input  logic        dq_oe,
  output logic [15:0] dq_in,
  output int          errs,
  output int          checks
);
  logic [15:0] mem [int];
  logic [11:0] open_row [4];
  logic        open_v [4];
  logic [15:0] pipe [4];

  function automatic logic [15:0] dflt(int k);
    return k[15:0] ^ 16'h5A5A;
  endfunction

  initial begin
    errs = 0; checks = 0;
    for (int i = 0; i < 4; i++) begin open_v[i] = 1'b0; open_row[i] = '0; pipe[i] = 16'hBEEF; end
  end

  assign dq_in = pipe[CL-1];

  always @(posedge clk) begin
    logic [3:0]  c;
    int          k;
    logic [15:0] v;
    c = {cs_n, ras_n, cas_n, we_n};
    for (int i = 3; i > 0; i--) pipe[i] <= pipe[i-1];
    pipe[0] <= 16'hBEEF;
    case (c)
      4'b0011: begin open_row[ba] = addr; open_v[ba] = 1'b1; end
      4'b0010: if (addr[10]) for (int i = 0; i < 4; i++) open_v[i] = 1'b0;
      4'b0100, 4'b0101: begin
        checks++;
        if (!open_v[ba]) begin
          errs++;
          $display("FAIL R4: column command to closed bank %0d (got closed, expected open)", ba);
        end
        k = int'({ba, open_row[ba], addr[8:0]});
        v = mem.exists(k) ? mem[k] : dflt(k);
        if (c == 4'b0100) begin
          checks++;
          if (!dq_oe) begin
            errs++;
            $display("FAIL R7: write without output enable (got 0, expected 1)");
          end
          if (!dqm[0]) v[7:0]  = dq_out[7:0];
          if (!dqm[1]) v[15:8] = dq_out[15:8];
          mem[k] = v;
        end else begin
          if (dqm[0]) v[7:0]  = 8'hFF;
          if (dqm[1]) v[15:8] = 8'hFF;
          pipe[0] <= v;
        end
        open_v[ba] = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: tb/sdram_ctrl_test.sv
module sdram_ctrl_test;
  localparam int CL = 3, TI = 40, TRP = 2, TRCD = 2, TRFC = 6, TMRD = 2, RI = 200;
  localparam int LIM = RI + TRCD + CL + TRP + TRFC + TMRD + 4;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR  = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_valid, req_write, req_ready, rd_valid;
  logic [22:0] req_addr;
  logic [15:0] req_wdata, rd_data, sd_dq_out, sd_dq_in;
  logic [1:0]  req_be, sd_ba, sd_dqm;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [11:0] sd_addr;
  int m_errs, m_checks;

  sdram_ctrl #(.CAS_LAT(CL), .T_INIT(TI), .T_RP(TRP), .T_RCD(TRCD), .T_RFC(TRFC),
               .T_MRD(TMRD), .REFI(RI)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in));

  sdram_model #(.CL(CL)) mdl (
    .clk(clk), .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
    .ba(sd_ba), .addr(sd_addr), .dqm(sd_dqm), .dq_out(sd_dq_out), .dq_oe(sd_dq_oe),
    .dq_in(sd_dq_in), .errs(m_errs), .checks(m_checks));

  logic v2, w2, rdy2, rv2, cke2, cs2, ras2, cas2, we2, oe2;
  logic [22:0] a2;
  logic [15:0] wd2, rd2, dqo2, dqi2;
  logic [1:0]  be2, ba2, dqm2;
  logic [11:0] ad2;
  int m2_errs, m2_checks;

  sdram_ctrl #(.CAS_LAT(2), .T_INIT(TI), .T_RP(TRP), .T_RCD(TRCD), .T_RFC(TRFC),
               .T_MRD(TMRD), .REFI(RI)) uut2 (
    .clk(clk), .rst_n(rst_n), .req_valid(v2), .req_write(w2), .req_addr(a2),
    .req_wdata(wd2), .req_be(be2), .req_ready(rdy2), .rd_data(rd2), .rd_valid(rv2),
    .sd_cke(cke2), .sd_cs_n(cs2), .sd_ras_n(ras2), .sd_cas_n(cas2), .sd_we_n(we2),
    .sd_ba(ba2), .sd_addr(ad2), .sd_dqm(dqm2), .sd_dq_out(dqo2), .sd_dq_oe(oe2),
    .sd_dq_in(dqi2));

  sdram_model #(.CL(2)) mdl2 (
    .clk(clk), .cs_n(cs2), .ras_n(ras2), .cas_n(cas2), .we_n(we2), .ba(ba2),
    .addr(ad2), .dqm(dqm2), .dq_out(dqo2), .dq_oe(oe2), .dq_in(dqi2),
    .errs(m2_errs), .checks(m2_checks));

  int errors = 0, checks = 0;
  logic [15:0] shadow [int];
  logic [15:0] expq [$];
  logic [22:0] last_addr;
  logic [1:0]  last_be;
  logic [15:0] last_wdata;
  int cyc = 0, init_idx = 0, last_ref = 0, refs = 0, rd_age = 0;
  bit init_early = 0, rd_arm = 0, done2 = 0, ended = 0;

  function automatic logic [15:0] dflt(int k);
    return k[15:0] ^ 16'h5A5A;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors + m_errs + m2_errs,
               checks + m_checks + m2_checks);
      $finish;
    end
  endtask

  task automatic host(bit wr, logic [22:0] a, logic [15:0] d, logic [1:0] be);
    logic [15:0] old, v;
    int k;
    req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    last_addr = a; last_be = be; last_wdata = d;
    k = int'(a);
    old = shadow.exists(k) ? shadow[k] : dflt(k);
    if (wr) begin
      v = old;
      if (be[0]) v[7:0]  = d[7:0];
      if (be[1]) v[15:8] = d[15:8];
      shadow[k] = v;
    end else begin
      v = old;
      if (!be[0]) v[7:0]  = 8'h00;
      if (!be[1]) v[15:8] = 8'h00;
      expq.push_back(v);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(posedge clk) if (rst_n) cyc++;

  always @(negedge clk) begin
    logic [3:0] c;
    logic [15:0] e;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (rst_n) begin
      if (init_idx < 4 && req_ready) init_early = 1;
      if (c != C_NOP && init_idx < 4) begin
        case (init_idx)
          0: begin
            chk(c == C_PRE && sd_addr[10], "R2", "first command", c, C_PRE);
            chk(cyc >= TI, "R2", "power-up wait", cyc, TI);
          end
          1, 2: chk(c == C_REF, "R3", "init refresh", c, C_REF);
          default: begin
            chk(c == C_MRS, "R3", "mode load command", c, C_MRS);
            chk(sd_addr == 12'(CL << 4) && sd_ba == 2'd0, "R3", "mode word", sd_addr, CL << 4);
          end
        endcase
        init_idx++;
        if (c == C_REF) last_ref = cyc;
      end else if (c == C_REF) begin
        chk(cyc - last_ref <= LIM, "R10", "refresh gap", cyc - last_ref, LIM);
        last_ref = cyc;
        refs++;
      end
      if (c == C_ACT && init_idx >= 4)
        chk(sd_ba == last_addr[22:21] && sd_addr == last_addr[20:9], "R4", "activate bank/row",
            {sd_ba, sd_addr}, last_addr[22:9]);
      if (c == C_WR) begin
        chk(sd_ba == last_addr[22:21] && sd_addr[8:0] == last_addr[8:0], "R4", "write column",
            {sd_ba, sd_addr[8:0]}, {last_addr[22:21], last_addr[8:0]});
        chk(sd_dq_oe && sd_dq_out == last_wdata && sd_dqm == ~last_be, "R7", "write pins",
            {sd_dq_oe, sd_dqm, sd_dq_out}, {1'b1, ~last_be, last_wdata});
      end
      if (rd_arm) rd_age++;
      if (c == C_RD) begin
        chk(sd_ba == last_addr[22:21] && sd_addr[8:0] == last_addr[8:0], "R4", "read column",
            {sd_ba, sd_addr[8:0]}, {last_addr[22:21], last_addr[8:0]});
        chk(sd_dqm == ~last_be, "R9", "read mask", sd_dqm, ~last_be);
        chk(!sd_dq_oe, "R12", "oe during read", sd_dq_oe, 0);
        rd_age = 0; rd_arm = 1;
      end
      if (rd_valid) begin
        chk(rd_arm && rd_age == CL + 1, "R8", "read latency", rd_age, CL + 1);
        rd_arm = 0;
        if (expq.size() == 0) chk(0, "R8", "unexpected read data", rd_data, 0);
        else begin
          e = expq.pop_front();
          chk(rd_data == e, "R8/R9", "read data", rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WATCHDOG", "run did not finish", 0, 1);
    finish_up();
  end

  initial begin
    int n;
    v2 = 0; w2 = 0; a2 = '0; wd2 = '0; be2 = 2'b11;
    @(posedge rst_n);
    @(negedge clk);
    w2 = 1; a2 = 23'h3F0155; wd2 = 16'hC0DE; v2 = 1;
    while (!rdy2) @(negedge clk);
    @(posedge clk); @(negedge clk); v2 = 0;
    w2 = 0; v2 = 1;
    while (!rdy2) @(negedge clk);
    @(posedge clk); @(negedge clk); v2 = 0;
    n = 1;
    while (!rv2 && n < 50) begin @(negedge clk); n++; end
    chk(n == TRCD + 2 + 2, "R11", "CAS 2 read latency", n, TRCD + 4);
    chk(rd2 == 16'hC0DE, "R11", "CAS 2 read data", rd2, 16'hC0DE);
    done2 = 1;
  end

  initial begin
    logic [22:0] a;
    int r0;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_be = 2'b11;
    last_addr = '0; last_be = 2'b11; last_wdata = '0;
    repeat (3) @(negedge clk);
    chk(!sd_cke, "R1", "cke in reset", sd_cke, 0);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1", "command in reset",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    chk(!req_ready && !rd_valid, "R1", "ready/valid in reset", {req_ready, rd_valid}, 0);
    rst_n = 1;
    while (init_idx < 4) @(negedge clk);
    chk(!init_early, "R3", "ready before mode load", init_early, 0);

    host(1, 23'h000123, 16'hA55A, 2'b11);
    host(0, 23'h000123, 16'h0, 2'b11);
    host(1, 23'h2ABCDE, 16'h1234, 2'b01);
    host(0, 23'h2ABCDE, 16'h0, 2'b11);
    host(0, 23'h2ABCDE, 16'h0, 2'b10);
    host(0, 23'h7FFFFF, 16'h0, 2'b11);
    host(1, 23'h7FFFFF, 16'hFFEE, 2'b10);
    host(0, 23'h7FFFFF, 16'h0, 2'b11);
    host(0, 23'h7FFFFF, 16'h0, 2'b01);

    for (int i = 0; i < 60; i++) begin
      a = 23'(i * 32'h00053A71 + 7);
      host(1, a, 16'(i * 16'h1357 + 16'h0101), (i % 5 == 0) ? 2'b01 : 2'b11);
      host(0, a, 16'h0, (i % 3 == 0) ? 2'b10 : 2'b11);
    end

    r0 = refs;
    repeat (3 * RI) @(negedge clk);
    chk(refs - r0 >= 2, "R10", "idle refreshes", refs - r0, 2);
    chk(expq.size() == 0, "R8", "reads outstanding", expq.size(), 0);
    while (!done2) @(negedge clk);
    finish_up();
  end
endmodule